// File: doc/BRIEF.md
# Serial Port Interrupt Request Generator

This block turns the status of a serial port's receive and transmit paths into interrupt requests. Four request lines go to an interrupt controller. Transmit-ready and receive-ready requests follow their status flags, qualified by per-source enables. A receive request that carries a parity, framing or overrun error is routed to a separate exception line, which takes precedence over the plain receive line. An idle-line request fires once for each idle period of the receive line. It stays latched until the interrupt controller acknowledges it, and it can fire again only after a new character has been received.

The enables sit in a small control register inside the block, written through a strobe. A hardware reset clears every enable. A software reset command clears the transmit, receive and idle enables but keeps the exception enable. The status flags, the character-received pulse and the acknowledge come from the surrounding datapath and interrupt controller, which are outside this block. Every request output is a register.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While `rst` is high and on the first clock after it, all four request outputs are low, all enables are cleared, and the idle request is armed.
- R2: A `ctl_we` pulse loads `ctl_wdata` into the enables: bit 0 is the transmit enable, bit 1 the receive enable, bit 2 the exception enable and bit 3 the idle enable. A request output reflects a new enable on the second rising edge after the write.
- R3: `irq_tx` equals (transmit enable AND `tx_empty`) as sampled on the previous rising edge.
- R4: `irq_rx_exc` equals (exception enable AND `rx_full` AND any bit of `rx_err`) as sampled on the previous rising edge.
- R5: `irq_rx` equals (receive enable AND `rx_full`) from the previous edge, except that it stays low whenever the exception condition of R4 held on that edge. `irq_rx` and `irq_rx_exc` are never high together.
- R6: When the idle request is armed, a rising edge that samples `line_idle` and the idle enable both high sets `irq_idle` and disarms the request. `irq_idle` stays high while `line_idle` stays high.
- R7: A rising edge that samples `idle_ack` high and fires no new idle request clears `irq_idle`. A new firing on the same edge takes precedence over the acknowledge.
- R8: Once disarmed, the idle request cannot fire again, however long the line stays idle or how often it toggles, until `char_rcvd` has been sampled high.
- R9: A `char_rcvd` pulse on the same edge as an idle condition rearms first and then evaluates, so the idle request fires on that edge. With the idle enable low, an idle line does not disarm the request.
- R10: A `soft_rst` pulse clears the transmit, receive and idle enables and keeps the exception enable. It takes precedence over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| ctl_we | input | 1 | Enable register write strobe |
| ctl_wdata | input | 4 | Enable bits: tx, rx, exception, idle (bits 0 to 3) |
| soft_rst | input | 1 | Software reset command pulse |
| tx_empty | input | 1 | Transmit buffer empty flag |
| rx_full | input | 1 | Receive buffer full flag |
| rx_err | input | ERR_W | Error flags: parity, framing, overrun |
| line_idle | input | 1 | Receive line idle status |
| char_rcvd | input | 1 | Single-cycle pulse, a character was received |
| idle_ack | input | 1 | Acknowledge of the idle request |
| irq_tx | output | 1 | Transmit request |
| irq_rx | output | 1 | Receive request |
| irq_rx_exc | output | 1 | Receive-with-exception request |
| irq_idle | output | 1 | Idle-line request |

## Verification
The hardest state to reach from the ports is a disarmed idle request facing a line that is idle again, because only the arming history tells a correct refusal apart from a missed firing. The bench builds that history on purpose. It fires the request, acknowledges it, holds the line idle and toggles it with no character in between, then rearms it: first with a separate `char_rcvd` pulse, then with a pulse that arrives in the same cycle as the idle condition. The level requests are swept over every combination of enables, buffer flags and error bits.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int CTL_W   = 4;
  localparam int BIT_TX  = 0;
  localparam int BIT_RX  = 1;
  localparam int BIT_EXC = 2;
  localparam int BIT_IDL = 3;

  typedef struct packed {
    logic idle;
    logic exc;
    logic rx;
    logic tx;
  } irq_en_t;
endpackage

// File: rtl/uart_irq_ctl_reg.sv
module uart_irq_ctl_reg
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  input  logic             soft_rst,
  output irq_en_t          en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en <= '0;
    end else if (soft_rst) begin
      en.tx   <= 1'b0;
      en.rx   <= 1'b0;
      en.idle <= 1'b0;
    end else if (we) begin
      en.tx   <= wdata[BIT_TX];
      en.rx   <= wdata[BIT_RX];
      en.exc  <= wdata[BIT_EXC];
      en.idle <= wdata[BIT_IDL];
    end
  end

  // R10: soft reset clears three enables, keeps the exception enable
  a_r10_soft_clears: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!en.tx && !en.rx && !en.idle && (en.exc == $past(en.exc))));
endmodule

// File: rtl/uart_irq_level_req.sv
module uart_irq_level_req
  import uart_irq_pkg::*;
#(
  parameter int ERR_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  irq_en_t          en,
  input  logic             tx_empty,
  input  logic             rx_full,
  input  logic [ERR_W-1:0] rx_err,
  output logic             irq_tx,
  output logic             irq_rx,
  output logic             irq_rx_exc
);
  logic exc_hit;
  assign exc_hit = en.exc && rx_full && (|rx_err);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_tx     <= 1'b0;
      irq_rx     <= 1'b0;
      irq_rx_exc <= 1'b0;
    end else begin
      irq_tx     <= en.tx && tx_empty;
      irq_rx_exc <= exc_hit;
      irq_rx     <= en.rx && rx_full && !exc_hit;
    end
  end

  // R5: plain and exception receive requests are exclusive
  a_r5_rx_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(irq_rx && irq_rx_exc));
  // R3: no transmit request without an empty buffer on the previous edge
  a_r3_tx_needs_empty: assert property (@(posedge clk) disable iff (rst)
    !tx_empty |=> !irq_tx);
  // R4: no exception request without an error flag
  a_r4_exc_needs_err: assert property (@(posedge clk) disable iff (rst)
    (rx_err == '0) |=> !irq_rx_exc);
endmodule

// File: rtl/uart_irq_idle_req.sv
module uart_irq_idle_req (
  input  logic clk,
  input  logic rst,
  input  logic idle_en,
  input  logic line_idle,
  input  logic char_rcvd,
  input  logic idle_ack,
  output logic irq_idle
);
  logic armed_q;
  logic armed_eff;
  logic fire;

  assign armed_eff = armed_q || char_rcvd;
  assign fire      = armed_eff && line_idle && idle_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q  <= 1'b1;
      irq_idle <= 1'b0;
    end else begin
      armed_q <= fire ? 1'b0 : armed_eff;
      if (fire)
        irq_idle <= 1'b1;
      else if (idle_ack)
        irq_idle <= 1'b0;
    end
  end

  // R7: acknowledge with no idle line clears the request
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (idle_ack && !line_idle) |=> !irq_idle);
  // R8: a disarmed request cannot rise without a received character
  a_r8_no_refire: assert property (@(posedge clk) disable iff (rst)
    (!armed_q && !char_rcvd) |=> !$rose(irq_idle));
  // R6: the request only rises on an idle line with the enable set
  a_r6_rise_cause: assert property (@(posedge clk) disable iff (rst)
    (!line_idle || !idle_en) |=> !$rose(irq_idle));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int ERR_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             soft_rst,
  input  logic             tx_empty,
  input  logic             rx_full,
  input  logic [ERR_W-1:0] rx_err,
  input  logic             line_idle,
  input  logic             char_rcvd,
  input  logic             idle_ack,
  output logic             irq_tx,
  output logic             irq_rx,
  output logic             irq_rx_exc,
  output logic             irq_idle
);
  irq_en_t en;

  uart_irq_ctl_reg u_ctl (
    .clk(clk), .rst(rst), .we(ctl_we), .wdata(ctl_wdata),
    .soft_rst(soft_rst), .en(en)
  );

  uart_irq_level_req #(.ERR_W(ERR_W)) u_lvl (
    .clk(clk), .rst(rst), .en(en), .tx_empty(tx_empty), .rx_full(rx_full),
    .rx_err(rx_err), .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_rx_exc(irq_rx_exc)
  );

  uart_irq_idle_req u_idle (
    .clk(clk), .rst(rst), .idle_en(en.idle), .line_idle(line_idle),
    .char_rcvd(char_rcvd), .idle_ack(idle_ack), .irq_idle(irq_idle)
  );

  // R1: outputs are low on the edge after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !(irq_tx || irq_rx || irq_rx_exc || irq_idle));
endmodule

// File: tb/uart_irq_ctrl_bench.sv
module uart_irq_ctrl_bench;
  localparam int ERR_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_we = 1'b0;
  logic [3:0] ctl_wdata = '0;
  logic soft_rst = 1'b0;
  logic tx_empty = 1'b0, rx_full = 1'b0;
  logic [ERR_W-1:0] rx_err = '0;
  logic line_idle = 1'b0, char_rcvd = 1'b0, idle_ack = 1'b0;
  logic irq_tx, irq_rx, irq_rx_exc, irq_idle;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_irq_ctrl #(.ERR_W(ERR_W)) u_uart_irq_ctrl (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .soft_rst(soft_rst), .tx_empty(tx_empty), .rx_full(rx_full),
    .rx_err(rx_err), .line_idle(line_idle), .char_rcvd(char_rcvd),
    .idle_ack(idle_ack), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .irq_rx_exc(irq_rx_exc), .irq_idle(irq_idle)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] v);
    ctl_wdata = v; ctl_we = 1'b1; step(); ctl_we = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    // R1: inputs active during reset, outputs stay low
    tx_empty = 1; rx_full = 1; rx_err = 3'b001; line_idle = 0;
    step();
    chk("R1 irq_tx in reset", irq_tx, 0);
    chk("R1 irq_rx in reset", irq_rx, 0);
    rst = 0; step();
    chk("R1 irq_tx after reset", irq_tx, 0);
    chk("R1 irq_rx_exc after reset", irq_rx_exc, 0);
    chk("R1 irq_idle after reset", irq_idle, 0);

    // R2..R5 sweep over enables and status flags, idle enable kept low
    for (int e = 0; e < 8; e++) begin
      wr(4'(e)); step();
      for (int d = 0; d < 32; d++) begin
        logic xe, xt, xr, xx;
        tx_empty = d[0]; rx_full = d[1]; rx_err = 3'(d >> 2);
        step();
        xt = e[0] && d[0];
        xx = e[2] && d[1] && (d[4:2] != 0);
        xr = e[1] && d[1] && !xx;
        chk("R3 irq_tx sweep", irq_tx, xt);
        chk("R5 irq_rx sweep", irq_rx, xr);
        chk("R4 irq_rx_exc sweep", irq_rx_exc, xx);
        xe = 0;
        chk("R2 irq_idle with enable low", irq_idle, xe);
      end
    end

    // R2: write latency, two edges
    tx_empty = 1; rx_full = 0; rx_err = 0;
    wr(4'b0000); step();
    ctl_wdata = 4'b0001; ctl_we = 1; step(); ctl_we = 0;
    chk("R2 one edge after write", irq_tx, 0);
    step();
    chk("R2 two edges after write", irq_tx, 1);

    // R10: soft reset keeps exception enable, beats a write
    wr(4'b0111); rx_full = 1; rx_err = 3'b100; step(); step();
    chk("R10 exc before soft reset", irq_rx_exc, 1);
    soft_rst = 1; ctl_wdata = 4'b1111; ctl_we = 1; step();
    soft_rst = 0; ctl_we = 0; step();
    chk("R10 tx cleared", irq_tx, 0);
    chk("R10 exc kept", irq_rx_exc, 1);
    rx_err = 0; step();
    chk("R10 rx enable cleared", irq_rx, 0);
    rx_full = 0; tx_empty = 0;

    // R6: first idle fires, holds
    wr(4'b1000); step();
    chk("R9 enable off no fire yet", irq_idle, 0);
    line_idle = 1; step();
    chk("R6 idle fires", irq_idle, 1);
    repeat (5) step();
    chk("R6 idle holds", irq_idle, 1);
    // R7: acknowledge clears
    idle_ack = 1; step(); idle_ack = 0;
    chk("R7 ack clears", irq_idle, 0);
    repeat (6) step();
    chk("R8 long idle no refire", irq_idle, 0);
    line_idle = 0; step(); step(); line_idle = 1; step(); step();
    chk("R8 toggle without char no refire", irq_idle, 0);
    // R8: rearm through a separate char pulse
    line_idle = 0; char_rcvd = 1; step(); char_rcvd = 0; step();
    chk("R8 no fire while busy", irq_idle, 0);
    line_idle = 1; step();
    chk("R8 rearmed fires", irq_idle, 1);
    idle_ack = 1; step(); idle_ack = 0;
    chk("R7 ack clears again", irq_idle, 0);
    // R9: char and idle on the same edge
    char_rcvd = 1; step(); char_rcvd = 0;
    chk("R9 same-cycle rearm fires", irq_idle, 1);
    // R7: new firing beats ack on the same edge
    idle_ack = 1; char_rcvd = 1; step(); idle_ack = 0; char_rcvd = 0;
    chk("R7 fire beats ack", irq_idle, 1);
    idle_ack = 1; step(); idle_ack = 0;
    chk("R7 ack after fire", irq_idle, 0);
    // R9: enable low does not disarm
    line_idle = 0; char_rcvd = 1; step(); char_rcvd = 0;
    wr(4'b0000); line_idle = 1; repeat (4) step();
    chk("R9 enable low no fire", irq_idle, 0);
    ctl_wdata = 4'b1000; ctl_we = 1; step(); ctl_we = 0;
    chk("R9 one edge after enable", irq_idle, 0);
    step();
    chk("R9 still armed, fires", irq_idle, 1);
    // R1: hardware reset clears request and enables
    rst = 1; step(); rst = 0; step();
    chk("R1 reset clears idle", irq_idle, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule